// File: doc/BRIEF.md
# Scrambled STS-1 Transmit Frame Generator

This block produces the transmit byte stream of an STS-1 style frame, one byte for each clock cycle in which the byte enable is high. A frame is 9 rows of 90 bytes, sent row by row. The block places the two framing bytes at the start of each frame. It also places a parity byte over the previous frame, three section data-channel bytes taken from an internal pseudo-random generator, and nine line data-channel bytes taken from a 72-bit text input. Every other byte position carries the payload input byte.

Each byte except the two framing bytes is XORed with a frame-synchronous scrambler key before it leaves. Every output byte comes with a valid flag, a start-of-frame strobe, and the 1-based row and column it occupies.

A three-state machine tracks where the generator is in the frame. FS_A1 emits the first framing byte. FS_A1 goes to FS_A2 on an enabled cycle. FS_A2 emits the second framing byte and goes to FS_BODY on an enabled cycle. FS_BODY emits scrambled bytes and returns to FS_A1 on the enabled cycle that emits row 9, column 90. Reset enters FS_A1. With the enable low, no state moves.

Top module: `sts1_frame_gen`

## Requirements
- R1: During reset, tx_valid, tx_sof, tx_byte, tx_row and tx_col are all zero. tx_valid is high exactly one cycle after each cycle with byte_en high. A cycle with byte_en low leaves tx_byte, tx_row and tx_col unchanged and drives tx_valid and tx_sof low on the next cycle.
- R2: Emitted positions run through column 1 to 90 of row 1, then row 2, and so on up to row 9, and then wrap to row 1, column 1. The first byte after reset is row 1, column 1.
- R3: Row 1, column 1 carries 0xF6 and row 1, column 2 carries 0x28, both unscrambled. tx_sof is high only with the 0xF6 byte. Bit 7 of tx_byte is the first bit on the line.
- R4: Every other byte is XORed with a key from the generator 1 + x^6 + x^7. The key restarts from all ones at row 1, column 3. It takes 8 key bits per byte, most significant bit first, so the key bytes start 0xFE, 0x04, 0x18. The key advances only on scrambled bytes that are actually emitted.
- R5: Row 2, column 1 holds, before scrambling, the bitwise XOR of all 810 transmitted bytes of the previous frame. In the first frame after reset it holds 0x00.
- R6: Row 3, columns 1 to 3 hold, before scrambling, consecutive bytes of a PRBS-7 (x^7 + x^6 + 1) sequence, most significant bit first. The sequence is seeded to all ones by reset, so the first three bytes are 0xFE, 0x04, 0x18. It continues across frames.
- R7: Rows 6, 7 and 8, columns 1 to 3, hold dcc_text byte k before scrambling, with k = (row - 6) * 3 + (column - 1), taken from dcc_text[8k+7:8k].
- R8: All remaining positions hold, before scrambling, the payload_in value present on the enabled clock edge that emits them.
- R9: The PRBS-7 state never becomes all zeros, so no section data-channel byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_en | input | 1 | Emit one byte on this edge |
| payload_in | input | 8 | Payload byte for non-overhead positions |
| dcc_text | input | 72 | Nine text bytes for the line data channel, byte 0 in bits 7:0 |
| tx_byte | output | 8 | Transmitted byte, MSB sent first |
| tx_valid | output | 1 | tx_byte holds a newly emitted byte |
| tx_sof | output | 1 | Start of frame, high with the first framing byte |
| tx_row | output | 4 | Row of tx_byte, 1 to 9 |
| tx_col | output | 7 | Column of tx_byte, 1 to 90 |

## Verification
A position counter that drifts from the state machine shows up at once as a framing byte outside row 1, or as a start strobe in the wrong place. A scrambler key that moves on an idle cycle corrupts every later payload byte of that frame when it is descrambled. A faulty parity accumulator stays hidden until row 2, column 1 of the next frame, about 90 bytes into it. A faulty PRBS state shows only in row 3 of each frame, so the bench checks its bytes over several frames and again after a mid-frame reset.

// File: rtl/sts1_pkg.sv
`timescale 1ns/1ps
package sts1_pkg;
    localparam int ROWS       = 9;
    localparam int COLS       = 90;
    localparam int ROW_W      = $clog2(ROWS + 1);
    localparam int COL_W      = $clog2(COLS + 1);
    localparam int B1_ROW     = 2;
    localparam int DSEC_ROW   = 3;
    localparam int DCC_COLS   = 3;
    localparam int LINE_ROW0  = 6;
    localparam int LINE_ROWS  = 3;
    localparam int TEXT_BYTES = LINE_ROWS * DCC_COLS;
    localparam int TEXT_W     = 8 * TEXT_BYTES;
    localparam int LFSR_W     = 7;

    typedef enum logic [1:0] {
        FS_A1   = 2'd0,
        FS_A2   = 2'd1,
        FS_BODY = 2'd2
    } fstate_e;

    typedef enum logic [1:0] {
        BK_B1    = 2'd0,
        BK_DSEC  = 2'd1,
        BK_DLINE = 2'd2,
        BK_PAY   = 2'd3
    } bkind_e;

    function automatic bkind_e classify(input logic [ROW_W-1:0] row,
                                        input logic [COL_W-1:0] col);
        bkind_e k;
        k = BK_PAY;
        if (int'(row) == B1_ROW && int'(col) == 1)
            k = BK_B1;
        else if (int'(row) == DSEC_ROW && int'(col) <= DCC_COLS)
            k = BK_DSEC;
        else if (int'(row) >= LINE_ROW0 && int'(row) < LINE_ROW0 + LINE_ROWS
                 && int'(col) <= DCC_COLS)
            k = BK_DLINE;
        return k;
    endfunction

    // Eight steps of the x^7 + x^6 + 1 register: {key byte, next state}
    function automatic logic [8+LFSR_W-1:0] lfsr7_byte(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] st;
        logic [7:0]        k;
        st = s;
        k  = '0;
        for (int b = 7; b >= 0; b--) begin
            k[b] = st[LFSR_W-1];
            st   = {st[LFSR_W-2:0], st[LFSR_W-1] ^ st[LFSR_W-2]};
        end
        return {k, st};
    endfunction
endpackage

// File: rtl/sts1_pos_ctr.sv
`timescale 1ns/1ps
module sts1_pos_ctr
    import sts1_pkg::*;
#(
    parameter int N_ROWS = ROWS,
    parameter int N_COLS = COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic             last
);
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             row_end;

    assign row_end = (int'(col_q) == N_COLS);
    assign last    = row_end && (int'(row_q) == N_ROWS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= ROW_W'(1);
            col_q <= COL_W'(1);
        end else if (adv) begin
            if (row_end) begin
                col_q <= COL_W'(1);
                row_q <= last ? ROW_W'(1) : row_q + ROW_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

    assign row = row_q;
    assign col = col_q;
endmodule

// File: rtl/sts1_lfsr7.sv
`timescale 1ns/1ps
module sts1_lfsr7
    import sts1_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED       = '1,
    parameter bit                ZERO_GUARD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              adv,
    output logic [7:0]        key,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] st_q;
    logic [LFSR_W-1:0] base;
    logic [LFSR_W-1:0] nxt;

    generate
        if (ZERO_GUARD) begin : g_guard
            always_comb begin
                if (restart || st_q == '0) base = SEED;
                else                       base = st_q;
            end
        end else begin : g_plain
            always_comb base = restart ? SEED : st_q;
        end
    endgenerate

    assign {key, nxt} = lfsr7_byte(base);

    always_ff @(posedge clk) begin
        if (!rst_n)   st_q <= SEED;
        else if (adv) st_q <= nxt;
    end

    assign state = st_q;
endmodule

// File: rtl/sts1_bip8.sv
`timescale 1ns/1ps
module sts1_bip8 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         frame_end,
    input  logic [W-1:0] din,
    output logic [W-1:0] parity
);
    logic [W-1:0] acc_q;
    logic [W-1:0] par_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            par_q <= '0;
        end else if (adv) begin
            if (frame_end) begin
                par_q <= acc_q ^ din;
                acc_q <= '0;
            end else begin
                acc_q <= acc_q ^ din;
            end
        end
    end

    assign parity = par_q;
endmodule

// File: rtl/sts1_frame_gen.sv
`timescale 1ns/1ps
module sts1_frame_gen
    import sts1_pkg::*;
#(
    parameter logic [7:0]        A1_VAL    = 8'hF6,
    parameter logic [7:0]        A2_VAL    = 8'h28,
    parameter logic [LFSR_W-1:0] SCR_SEED  = '1,
    parameter logic [LFSR_W-1:0] PRBS_SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_en,
    input  logic [7:0]        payload_in,
    input  logic [TEXT_W-1:0] dcc_text,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    output logic              tx_sof,
    output logic [ROW_W-1:0]  tx_row,
    output logic [COL_W-1:0]  tx_col
);
    fstate_e           state_q, state_d;
    logic [ROW_W-1:0]  pos_row;
    logic [COL_W-1:0]  pos_col;
    logic              pos_last;
    bkind_e            kind;
    logic [7:0]        raw_byte, out_byte, text_byte;
    logic [7:0]        scr_key, prbs_key, b1_val;
    logic [LFSR_W-1:0] scr_st, prbs_st;
    logic              scr_en, scr_restart, is_a1, prbs_adv;

    sts1_pos_ctr #(.N_ROWS(ROWS), .N_COLS(COLS)) u_pos (
        .clk(clk), .rst_n(rst_n), .adv(byte_en),
        .row(pos_row), .col(pos_col), .last(pos_last)
    );

    assign kind        = classify(pos_row, pos_col);
    assign scr_restart = (int'(pos_row) == 1) && (int'(pos_col) == 3);
    assign prbs_adv    = byte_en && (state_q == FS_BODY) && (kind == BK_DSEC);

    sts1_lfsr7 #(.SEED(SCR_SEED), .ZERO_GUARD(1'b0)) u_scr (
        .clk(clk), .rst_n(rst_n), .restart(scr_restart),
        .adv(byte_en && scr_en), .key(scr_key), .state(scr_st)
    );

    sts1_lfsr7 #(.SEED(PRBS_SEED), .ZERO_GUARD(1'b1)) u_prbs (
        .clk(clk), .rst_n(rst_n), .restart(1'b0),
        .adv(prbs_adv), .key(prbs_key), .state(prbs_st)
    );

    sts1_bip8 #(.W(8)) u_bip (
        .clk(clk), .rst_n(rst_n), .adv(byte_en),
        .frame_end(pos_last), .din(out_byte), .parity(b1_val)
    );

    always_comb begin
        int ti;
        ti = (int'(pos_row) - LINE_ROW0) * DCC_COLS + int'(pos_col) - 1;
        text_byte = '0;
        for (int i = 0; i < TEXT_BYTES; i++)
            if (ti == i) text_byte = dcc_text[8*i +: 8];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_A1;
        else        state_q <= state_d;
    end

    // next state and byte selection
    always_comb begin
        state_d  = state_q;
        raw_byte = A1_VAL;
        scr_en   = 1'b0;
        is_a1    = 1'b0;
        unique case (state_q)
            FS_A1: begin
                raw_byte = A1_VAL;
                is_a1    = 1'b1;
                if (byte_en) state_d = FS_A2;
            end
            FS_A2: begin
                raw_byte = A2_VAL;
                if (byte_en) state_d = FS_BODY;
            end
            FS_BODY: begin
                scr_en = 1'b1;
                unique case (kind)
                    BK_B1:    raw_byte = b1_val;
                    BK_DSEC:  raw_byte = prbs_key;
                    BK_DLINE: raw_byte = text_byte;
                    BK_PAY:   raw_byte = payload_in;
                    default:  raw_byte = payload_in;
                endcase
                if (byte_en && pos_last) state_d = FS_A1;
            end
            default: begin
                state_d = FS_A1;
            end
        endcase
    end

    assign out_byte = scr_en ? (raw_byte ^ scr_key) : raw_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte  <= '0;
            tx_valid <= 1'b0;
            tx_sof   <= 1'b0;
            tx_row   <= '0;
            tx_col   <= '0;
        end else begin
            tx_valid <= byte_en;
            if (byte_en) begin
                tx_byte <= out_byte;
                tx_row  <= pos_row;
                tx_col  <= pos_col;
                tx_sof  <= is_a1;
            end else begin
                tx_sof  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sts1_frame_gen_chk.sv
`timescale 1ns/1ps
module sts1_frame_gen_chk
    import sts1_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              byte_en,
    input logic              tx_valid,
    input logic              tx_sof,
    input logic [7:0]        tx_byte,
    input logic [ROW_W-1:0]  tx_row,
    input logic [COL_W-1:0]  tx_col,
    input fstate_e           fsm_state,
    input logic [ROW_W-1:0]  pos_row,
    input logic [COL_W-1:0]  pos_col,
    input logic              pos_last,
    input logic [LFSR_W-1:0] prbs_st,
    input logic [LFSR_W-1:0] scr_st
);
    assert_en_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en |=> tx_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> (!tx_valid && !tx_sof && $stable(tx_byte) && $stable(tx_col)));

    assert_fsm_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == FS_A1) |-> (int'(pos_row) == 1 && int'(pos_col) == 1));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && pos_last && fsm_state == FS_BODY) |=> (fsm_state == FS_A1));

    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (int'(tx_row) >= 1 && int'(tx_row) <= ROWS &&
                      int'(tx_col) >= 1 && int'(tx_col) <= COLS));

    assert_sof_a1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> (tx_valid && tx_byte == 8'hF6 &&
                    int'(tx_row) == 1 && int'(tx_col) == 1));

    assert_a2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && int'(tx_row) == 1 && int'(tx_col) == 2) |-> (tx_byte == 8'h28));

    assert_scr_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scr_st != '0);

    assert_prbs_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prbs_st != '0);
endmodule

bind sts1_frame_gen sts1_frame_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en),
    .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_byte(tx_byte),
    .tx_row(tx_row), .tx_col(tx_col), .fsm_state(state_q),
    .pos_row(pos_row), .pos_col(pos_col), .pos_last(pos_last),
    .prbs_st(prbs_st), .scr_st(scr_st)
);

// File: tb/sts1_frame_gen_bench.sv
`timescale 1ns/1ps
module sts1_frame_gen_bench;
    localparam int NB = 810;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_en;
    logic [7:0]  payload_in;
    logic [71:0] dcc_text;
    logic [7:0]  tx_byte;
    logic        tx_valid, tx_sof;
    logic [3:0]  tx_row;
    logic [6:0]  tx_col;

    always #4 clk = ~clk;

    sts1_frame_gen u_sts1_frame_gen (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .payload_in(payload_in),
        .dcc_text(dcc_text), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .tx_sof(tx_sof), .tx_row(tx_row), .tx_col(tx_col)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] tx [NB];
    logic [7:0] rw [NB];
    logic [7:0] ks [NB];
    logic [6:0] pst;

    // row, col, expected pre-scramble byte for frame 1 (payload = row*16+col)
    localparam logic [18:0] VEC [14] = '{
        {4'd1, 7'd1,  8'hF6}, {4'd1, 7'd2,  8'h28}, {4'd1, 7'd3,  8'h13},
        {4'd2, 7'd1,  8'h00}, {4'd2, 7'd2,  8'h22}, {4'd3, 7'd1,  8'hFE},
        {4'd3, 7'd2,  8'h04}, {4'd3, 7'd3,  8'h18}, {4'd3, 7'd4,  8'h34},
        {4'd4, 7'd1,  8'h41}, {4'd6, 7'd1,  8'h41}, {4'd7, 7'd2,  8'h45},
        {4'd8, 7'd3,  8'h49}, {4'd9, 7'd90, 8'hEA}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay_of(input int r, input int c);
        return 8'((r * 16 + c) & 255);
    endfunction

    function automatic logic [7:0] prbs_next();
        logic [7:0] k;
        for (int b = 7; b >= 0; b--) begin
            k[b] = pst[6];
            pst  = {pst[5:0], pst[6] ^ pst[5]};
        end
        return k;
    endfunction

    task automatic step(input bit en, input int r, input int c);
        byte_en    = en;
        payload_in = en ? pay_of(r, c) : 8'h00;
        @(negedge clk);
    endtask

    task automatic run_frame(input bit gaps, input int fno);
        int pos_err = 0, idle_err = 0, sof_err = 0;
        logic [7:0] last;
        for (int k = 0; k < NB; k++) begin
            int r, c;
            r = k / 90 + 1;
            c = k % 90 + 1;
            if (gaps && (k % 3 == 0)) begin
                last = tx_byte;
                step(1'b0, r, c);
                if (tx_valid || tx_sof || tx_byte != last) idle_err++;
            end
            step(1'b1, r, c);
            if (!tx_valid || int'(tx_row) != r || int'(tx_col) != c) pos_err++;
            if (tx_sof != (k == 0)) sof_err++;
            tx[k] = tx_byte;
        end
        byte_en = 1'b0;
        chk(pos_err == 0, $sformatf("R2 position order frame %0d", fno), pos_err, 0);
        chk(sof_err == 0, $sformatf("R3 sof placement frame %0d", fno), sof_err, 0);
        if (gaps)
            chk(idle_err == 0, $sformatf("R1 idle cycles hold frame %0d", fno), idle_err, 0);
    endtask

    task automatic check_frame(input int fno, input logic [7:0] exp_b1, input logic [71:0] text);
        int pay_err = 0;
        for (int k = 0; k < NB; k++) rw[k] = (k < 2) ? tx[k] : (tx[k] ^ ks[k]);
        chk(tx[0] == 8'hF6 && tx[1] == 8'h28, $sformatf("R3 framing bytes frame %0d", fno),
            {tx[0], tx[1]}, 16'hF628);
        chk(rw[90] == exp_b1, $sformatf("R5 parity byte frame %0d", fno), rw[90], exp_b1);
        for (int d = 0; d < 3; d++) begin
            logic [7:0] e;
            e = prbs_next();
            chk(rw[180 + d] == e, $sformatf("R6 section byte %0d frame %0d", d, fno), rw[180 + d], e);
            chk(rw[180 + d] != 8'h00, $sformatf("R9 section byte nonzero frame %0d", fno), rw[180 + d], 1);
        end
        for (int t = 0; t < 9; t++) begin
            int k;
            k = (5 + t / 3) * 90 + (t % 3);
            chk(rw[k] == text[8*t +: 8], $sformatf("R7 line text byte %0d frame %0d", t, fno),
                rw[k], text[8*t +: 8]);
        end
        for (int k = 0; k < NB; k++) begin
            int r, c;
            r = k / 90 + 1;
            c = k % 90 + 1;
            if (!(r == 1 && c <= 2) && !(r == 2 && c == 1) && !(r == 3 && c <= 3) &&
                !(r >= 6 && r <= 8 && c <= 3))
                if (rw[k] != pay_of(r, c)) pay_err++;
        end
        chk(pay_err == 0, $sformatf("R8 payload positions frame %0d", fno), pay_err, 0);
        chk(tx[2] == (pay_of(1, 3) ^ 8'hFE), $sformatf("R4 first scrambled byte frame %0d", fno),
            tx[2], pay_of(1, 3) ^ 8'hFE);
    endtask

    function automatic logic [7:0] frame_xor();
        logic [7:0] x;
        x = '0;
        for (int k = 0; k < NB; k++) x ^= tx[k];
        return x;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b1;
        logic [6:0] s;
        s = 7'h7F;
        ks[0] = 8'h00;
        ks[1] = 8'h00;
        for (int k = 2; k < NB; k++) begin
            for (int b = 7; b >= 0; b--) begin
                ks[k][b] = s[6];
                s = {s[5:0], s[6] ^ s[5]};
            end
        end
        pst        = 7'h7F;
        rst_n      = 1'b0;
        byte_en    = 1'b0;
        payload_in = 8'h00;
        dcc_text   = "IHGFEDCBA";
        repeat (3) @(negedge clk);
        chk(tx_valid == 0 && tx_sof == 0 && tx_byte == 0 && tx_row == 0 && tx_col == 0,
            "R1 reset state", {tx_valid, tx_sof, tx_byte}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == 0, "R1 no valid without enable", tx_valid, 0);

        // frame 1: continuous enable, table of vectors
        run_frame(1'b0, 1);
        for (int k = 0; k < NB; k++) rw[k] = (k < 2) ? tx[k] : (tx[k] ^ ks[k]);
        for (int v = 0; v < 14; v++) begin
            int r, c, k;
            r = int'(VEC[v][18:15]);
            c = int'(VEC[v][14:8]);
            k = (r - 1) * 90 + (c - 1);
            chk(rw[k] == VEC[v][7:0], $sformatf("R3-R8 vector %0d at row %0d col %0d (R5 R6 R7 R8)", v, r, c),
                rw[k], VEC[v][7:0]);
        end
        check_frame(1, 8'h00, dcc_text);
        b1 = frame_xor();

        // frame 2: enable with gaps, scrambler must not advance while idle
        run_frame(1'b1, 2);
        check_frame(2, b1, dcc_text);
        b1 = frame_xor();

        // frame 3: new text
        dcc_text = "987654321";
        run_frame(1'b0, 3);
        check_frame(3, b1, dcc_text);

        // mid-frame reset
        for (int k = 0; k < 100; k++) step(1'b1, 1 + k / 90, 1 + k % 90);
        byte_en = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        chk(tx_valid == 0 && tx_sof == 0 && tx_byte == 0 && tx_row == 0 && tx_col == 0,
            "R1 mid-frame reset clears outputs", {tx_valid, tx_byte}, 0);
        rst_n = 1'b1;
        pst   = 7'h7F;
        run_frame(1'b0, 4);
        check_frame(4, 8'h00, dcc_text);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule